// File: doc/BRIEF.md
# Control Response Rate Selector

When a station receives a frame that must be answered with a control response (ACK, Block-ACK or CTS), this block chooses the transmit rate index and the preamble length of that response. Each request carries a 24-bit response configuration word, the rate index of the received frame, a response-kind code and the position of the secondary 40 MHz sub-channel. The block keeps only the configured basic rates that suit the response kind. From those it picks the fastest one that is not faster than the received frame. It also reports whether an RTS/CTS exchange must protect the secondary sub-channel.

Requests arrive on a valid/ready input stream, and one result leaves on a valid/ready output stream. A request is taken when `in_valid` and `in_ready` are both high at a rising clock edge. Its result appears in the output register one cycle later. The result stays in the register, unchanged, until the consumer raises `out_ready`. While a result is held, `in_ready` is low, so back-pressure reaches the producer without delay. A new request can be taken in the same cycle that the held result drains, so results can leave back to back.

Top module: `ctl_resp_rate_sel`

## Requirements
- R1: Rate index encoding. Configuration bits 0..19 are the basic-rate bitmap, one bit per rate index. Indices 0..3 are CCK 1/2/5.5/11 Mbps. Indices 4..11 are OFDM 6/9/12/18/24/36/48/54 Mbps. Indices 12..19 are MCS0..MCS7. Bit 20 is unused.
- R2: Response kind codes are 0 = ACK, 1 = Block-ACK, 2 = CTS and 3 = handled like ACK. A CTS, or an ACK/Block-ACK answering a non-HT frame, may use set CCK and OFDM bits. An ACK/Block-ACK answering an MCS frame (index 12..19) may use set OFDM bits only. MCS bits are never selected from the bitmap.
- R3: Ceiling of the received frame. A received CCK or OFDM index is its own ceiling. For a received MCS frame the ceiling is a mandatory OFDM rate: MCS0 gives 4, MCS1 and MCS2 give 6, and MCS3 to MCS7 give 8. A received index of 20..31 is treated as non-HT with ceiling 11.
- R4: When some eligible set bit has an index at or below the ceiling, the output rate is the highest such index.
- R5: When eligible set bits exist but all of them lie above the ceiling, the output rate is the lowest eligible set bit.
- R6: When no eligible set bit exists, an ACK/Block-ACK answering an MCS frame goes out at index 19 (MCS7). Every other case goes out at index 0 (CCK 1 Mbps).
- R7: `out_short` is high only when configuration bit 23 is set and the chosen rate index is 1, 2 or 3.
- R8: For a CTS, `out_sec` equals configuration bit 22 when `in_sec_upper` is 1 and bit 21 when it is 0. For every other kind, `out_sec` is 0 whatever bits 21 and 22 hold.
- R9: `in_ready` is high whenever no result is held or `out_ready` is high. An accepted request makes `out_valid` high on the next cycle. While `out_valid` is high and `out_ready` is low, the outputs do not change.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_cfg | input | 24 | Response configuration word (bitmap, sub-channel bits, short preamble) |
| in_rx_rate | input | 5 | Rate index of the received frame |
| in_kind | input | 2 | Response kind code |
| in_sec_upper | input | 1 | 1 when the secondary sub-channel lies above the primary |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_rate | output | 5 | Chosen response rate index |
| out_short | output | 1 | Use short preamble |
| out_sec | output | 1 | Exchange also covers the secondary sub-channel |

## Verification
Two functions can fall in the same clock edge: a held result drains and a new request is accepted. The bench provokes this by stalling the output with a result held and a second request waiting. While stalled, it checks that the held result does not change and that `in_ready` stays low. It then raises `out_ready` without dropping `in_valid`. The result of the second request must appear on the very next cycle, with no gap and no duplicate. Along the way the table walk checks the fallback and short-preamble rules together, on requests where both apply.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int CFG_W       = 24;
  localparam int SEC_LO_BIT  = 21;
  localparam int SEC_HI_BIT  = 22;
  localparam int SHORT_BIT   = 23;
  localparam int OFS_MCS1    = 2;
  localparam int OFS_MCS3    = 4;

  typedef enum logic [1:0] {
    KIND_ACK  = 2'd0,
    KIND_BACK = 2'd1,
    KIND_CTS  = 2'd2,
    KIND_RSV  = 2'd3
  } resp_kind_e;
endpackage

// File: rtl/rrs_ceiling.sv
module rrs_ceiling #(
  parameter int N_CCK  = 4,
  parameter int N_OFDM = 8,
  parameter int N_MCS  = 8,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0] rx_rate,
  output logic [IDX_W-1:0] ceil_idx,
  output logic             rx_is_ht
);
  import rrs_pkg::*;
  localparam int LEG_N  = N_CCK + N_OFDM;
  localparam int NRATE  = LEG_N + N_MCS;

  logic [IDX_W-1:0] mcs_num;

  always_comb begin
    mcs_num  = rx_rate - IDX_W'(LEG_N);
    rx_is_ht = 1'b0;
    ceil_idx = rx_rate;
    if (32'(rx_rate) >= NRATE) begin
      ceil_idx = IDX_W'(LEG_N - 1);
    end else if (32'(rx_rate) >= LEG_N) begin
      rx_is_ht = 1'b1;
      if (mcs_num == '0)
        ceil_idx = IDX_W'(N_CCK);
      else if (mcs_num < 3)
        ceil_idx = IDX_W'(N_CCK + OFS_MCS1);
      else
        ceil_idx = IDX_W'(N_CCK + OFS_MCS3);
    end
  end
endmodule

// File: rtl/rrs_mask.sv
module rrs_mask #(
  parameter int N_CCK  = 4,
  parameter int N_OFDM = 8,
  parameter int N_MCS  = 8,
  parameter int IDX_W  = 5
) (
  input  logic [N_CCK+N_OFDM+N_MCS-1:0] bitmap,
  input  logic                          ofdm_only,
  input  logic [IDX_W-1:0]              ceil_idx,
  output logic [N_CCK+N_OFDM+N_MCS-1:0] elig,
  output logic [N_CCK+N_OFDM+N_MCS-1:0] below
);
  localparam int NRATE = N_CCK + N_OFDM + N_MCS;

  for (genvar i = 0; i < NRATE; i++) begin : g_bit
    localparam logic [IDX_W-1:0] POS = IDX_W'(i);
    localparam bit IS_CCK  = (i < N_CCK);
    localparam bit IS_OFDM = (i >= N_CCK) && (i < N_CCK + N_OFDM);
    logic kind_ok;
    if (IS_OFDM) begin : g_ofdm
      assign kind_ok = 1'b1;
    end else if (IS_CCK) begin : g_cck
      assign kind_ok = !ofdm_only;
    end else begin : g_mcs
      assign kind_ok = 1'b0;
    end
    assign elig[i]  = bitmap[i] & kind_ok;
    assign below[i] = elig[i] & (POS <= ceil_idx);
  end
endmodule

// File: rtl/rrs_pick.sv
module rrs_pick #(
  parameter int N      = 20,
  parameter int IDX_W  = 5,
  parameter bit HIGHEST = 1'b1
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  assign found = |vec;

  if (HIGHEST) begin : g_high
    always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++)
        if (vec[i]) idx = IDX_W'(i);
    end
  end else begin : g_low
    always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--)
        if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ctl_resp_rate_sel.sv
module ctl_resp_rate_sel #(
  parameter int N_CCK  = 4,
  parameter int N_OFDM = 8,
  parameter int N_MCS  = 8,
  parameter int IDX_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [rrs_pkg::CFG_W-1:0] in_cfg,
  input  logic [IDX_W-1:0]         in_rx_rate,
  input  logic [1:0]               in_kind,
  input  logic                     in_sec_upper,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [IDX_W-1:0]         out_rate,
  output logic                     out_short,
  output logic                     out_sec
);
  import rrs_pkg::*;
  localparam int NRATE = N_CCK + N_OFDM + N_MCS;
  localparam logic [IDX_W-1:0] FALLBACK_IDX = IDX_W'(NRATE - 1);

  logic [IDX_W-1:0] ceil_idx;
  logic             rx_is_ht;
  logic             ht_ack;
  logic [NRATE-1:0] elig, below;
  logic             hi_found, lo_found;
  logic [IDX_W-1:0] hi_idx, lo_idx;
  logic [IDX_W-1:0] sel_rate;
  logic             sel_short, sel_sec;
  logic             take;

  rrs_ceiling #(.N_CCK(N_CCK), .N_OFDM(N_OFDM), .N_MCS(N_MCS), .IDX_W(IDX_W)) u_ceil (
    .rx_rate (in_rx_rate),
    .ceil_idx(ceil_idx),
    .rx_is_ht(rx_is_ht)
  );

  assign ht_ack = rx_is_ht && (in_kind != KIND_CTS);

  rrs_mask #(.N_CCK(N_CCK), .N_OFDM(N_OFDM), .N_MCS(N_MCS), .IDX_W(IDX_W)) u_mask (
    .bitmap   (in_cfg[NRATE-1:0]),
    .ofdm_only(ht_ack),
    .ceil_idx (ceil_idx),
    .elig     (elig),
    .below    (below)
  );

  rrs_pick #(.N(NRATE), .IDX_W(IDX_W), .HIGHEST(1'b1)) u_pick_hi (
    .vec(below), .found(hi_found), .idx(hi_idx)
  );

  rrs_pick #(.N(NRATE), .IDX_W(IDX_W), .HIGHEST(1'b0)) u_pick_lo (
    .vec(elig), .found(lo_found), .idx(lo_idx)
  );

  always_comb begin
    if (hi_found)      sel_rate = hi_idx;
    else if (lo_found) sel_rate = lo_idx;
    else if (ht_ack)   sel_rate = FALLBACK_IDX;
    else               sel_rate = '0;
  end

  assign sel_short = in_cfg[SHORT_BIT] && (sel_rate != '0) && (32'(sel_rate) < N_CCK);
  assign sel_sec   = (in_kind == KIND_CTS) &&
                     (in_sec_upper ? in_cfg[SEC_HI_BIT] : in_cfg[SEC_LO_BIT]);

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rate  <= '0;
      out_short <= 1'b0;
      out_sec   <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_rate  <= sel_rate;
        out_short <= sel_short;
        out_sec   <= sel_sec;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctl_resp_rate_sel_chk.sv
module ctl_resp_rate_sel_chk #(
  parameter int N_CCK  = 4,
  parameter int N_OFDM = 8,
  parameter int N_MCS  = 8,
  parameter int IDX_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_rate,
  input logic             out_short,
  input logic             out_sec
);
  localparam int LEG_N = N_CCK + N_OFDM;
  localparam int NRATE = LEG_N + N_MCS;

  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9

  AST_HELD_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rate) &&
                                $stable(out_short) && $stable(out_sec)); // R9

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9

  AST_SHORT_ONLY_CCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_short |-> (out_rate != '0) && (32'(out_rate) < N_CCK)); // R7

  AST_LEGACY_OR_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_rate) < LEG_N) || (32'(out_rate) == NRATE - 1)); // R2
endmodule

bind ctl_resp_rate_sel ctl_resp_rate_sel_chk #(
  .N_CCK(N_CCK), .N_OFDM(N_OFDM), .N_MCS(N_MCS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_rate(out_rate),
  .out_short(out_short), .out_sec(out_sec)
);

// File: tb/test_ctl_resp_rate_sel.sv
module test_ctl_resp_rate_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_cfg = '0;
  logic [4:0]  in_rx_rate = '0;
  logic [1:0]  in_kind = '0;
  logic        in_sec_upper = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  out_rate;
  logic        out_short;
  logic        out_sec;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ctl_resp_rate_sel i_ctl_resp_rate_sel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cfg(in_cfg), .in_rx_rate(in_rx_rate), .in_kind(in_kind),
    .in_sec_upper(in_sec_upper), .out_valid(out_valid), .out_ready(out_ready),
    .out_rate(out_rate), .out_short(out_short), .out_sec(out_sec)
  );

  // {cfg, rx, kind, sec_upper, exp_rate, exp_short, exp_sec}
  localparam int NV = 19;
  localparam logic [38:0] VECS [NV] = '{
    {24'h001153, 5'd11, 2'd0, 1'b0, 5'd8,  1'b0, 1'b0}, // R4 legacy ceiling
    {24'h001153, 5'd3,  2'd0, 1'b0, 5'd1,  1'b0, 1'b0}, // R4 CCK ceiling
    {24'h801153, 5'd3,  2'd0, 1'b0, 5'd1,  1'b1, 1'b0}, // R7 short
    {24'h001153, 5'd12, 2'd0, 1'b0, 5'd4,  1'b0, 1'b0}, // R3 MCS0
    {24'h001153, 5'd15, 2'd1, 1'b0, 5'd8,  1'b0, 1'b0}, // R3 MCS3 BA
    {24'h001153, 5'd13, 2'd0, 1'b0, 5'd6,  1'b0, 1'b0}, // R3 MCS1
    {24'h201153, 5'd19, 2'd2, 1'b0, 5'd8,  1'b0, 1'b1}, // R8 lower bit
    {24'h201153, 5'd19, 2'd2, 1'b1, 5'd8,  1'b0, 1'b0}, // R8 upper bit
    {24'h801003, 5'd12, 2'd0, 1'b0, 5'd19, 1'b0, 1'b0}, // R6 MCS7 fallback
    {24'h801003, 5'd12, 2'd2, 1'b1, 5'd1,  1'b1, 1'b0}, // R2 CTS uses CCK
    {24'h000100, 5'd4,  2'd0, 1'b0, 5'd8,  1'b0, 1'b0}, // R5 lowest above
    {24'h000000, 5'd5,  2'd2, 1'b0, 5'd0,  1'b0, 1'b0}, // R6 empty -> 0
    {24'h800000, 5'd5,  2'd0, 1'b0, 5'd0,  1'b0, 1'b0}, // R7 CCK1 long
    {24'h80000C, 5'd2,  2'd0, 1'b0, 5'd2,  1'b1, 1'b0}, // R7 CCK5.5
    {24'h000FF0, 5'd25, 2'd0, 1'b0, 5'd11, 1'b0, 1'b0}, // R3 out of range
    {24'h001153, 5'd14, 2'd3, 1'b0, 5'd6,  1'b0, 1'b0}, // R2 kind 3
    {24'h401153, 5'd4,  2'd2, 1'b1, 5'd4,  1'b0, 1'b1}, // R8 CTS upper
    {24'h601153, 5'd4,  2'd0, 1'b1, 5'd4,  1'b0, 1'b0}, // R8 ACK ignores
    {24'h1FF003, 5'd11, 2'd0, 1'b0, 5'd1,  1'b0, 1'b0}  // R1 MCS bits unused
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<5000", cyc);
      done = 1'b1;
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 out_valid", 32'(out_valid), 0);
    check("R10 in_ready", 32'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", 32'(out_valid), 0);

    // table walk, one request per cycle with out_ready high
    for (int k = 0; k < NV; k++) begin
      in_cfg       = VECS[k][38:15];
      in_rx_rate   = VECS[k][14:10];
      in_kind      = VECS[k][9:8];
      in_sec_upper = VECS[k][7];
      in_valid     = 1'b1;
      out_ready    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R9 valid vec%0d", k), 32'(out_valid), 1);
      check($sformatf("R4/R5/R6 rate vec%0d", k), 32'(out_rate), 32'(VECS[k][6:2]));
      check($sformatf("R7 short vec%0d", k), 32'(out_short), 32'(VECS[k][1]));
      check($sformatf("R8 sec vec%0d", k), 32'(out_sec), 32'(VECS[k][0]));
    end
    @(posedge clk);
    @(negedge clk);
    check("R9 drains", 32'(out_valid), 0);

    // back-pressure with a waiting request, then drain and accept together
    out_ready = 1'b0;
    in_cfg = 24'h801153; in_rx_rate = 5'd3; in_kind = 2'd0; in_sec_upper = 1'b0;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_cfg = 24'h001153; in_rx_rate = 5'd11; in_kind = 2'd0;
    check("R9 stall in_ready", 32'(in_ready), 0);
    check("R9 first result", 32'(out_rate), 1);
    check("R7 first short", 32'(out_short), 1);
    @(posedge clk);
    @(negedge clk);
    check("R9 hold valid", 32'(out_valid), 1);
    check("R9 hold rate", 32'(out_rate), 1);
    check("R9 hold short", 32'(out_short), 1);
    check("R9 stall in_ready 2", 32'(in_ready), 0);
    out_ready = 1'b1;
    #1;
    check("R9 ready follows out_ready", 32'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 back-to-back valid", 32'(out_valid), 1);
    check("R9 back-to-back rate", 32'(out_rate), 8);
    check("R7 back-to-back short", 32'(out_short), 0);
    @(posedge clk);
    @(negedge clk);
    check("R9 empty after drain", 32'(out_valid), 0);

    // reset while a result is held
    out_ready = 1'b0;
    in_cfg = 24'h001153; in_rx_rate = 5'd4; in_kind = 2'd2; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 held before reset", 32'(out_valid), 1);
    rst_n = 1'b0;
    #1;
    check("R10 reset clears valid", 32'(out_valid), 0);
    check("R10 reset in_ready", 32'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule